// File: doc/BRIEF.md
# SMBus Strap-Configured Target Address Decoder

This block sits behind an SMBus slave front end on a processor module. The front end assembles the first byte of each transaction and strobes it in. The decoder then decides which of three on-module targets is being addressed: a scratch EEPROM, an information ROM or a thermal sensor. It also reports the direction bit. Slot straps set the addresses of these targets. Two straps are binary (SA0, SA1). The third strap (SA2) has three levels and arrives as a two-bit code: 00 means low, 01 means high, 10 means floating and 11 is illegal.

The straps are sampled once. This happens on the first clock edge after reset is released, and the sampled values are then held until the next reset. A small state machine controls this. It waits in `ST_ARMED` while reset is active. On the first clock after release it samples the straps. It then moves to `ST_LOCKED_ALL` if the SA2 code is legal, or to `ST_LOCKED_MEM` if the code is 11, in which case the sensor is disabled. It stays in that state until the next reset. Decode results are registered. They appear as a one-cycle pulse, together with `dec_valid`, on the clock after the strobe.

An outer controller uses `nomatch_flag` to decide whether to withhold ACK. It uses the select lines to steer the rest of the transaction.

Top module: `smb_addr_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dec_valid`, all three selects, `rd_flag`, `reserved_flag` and `nomatch_flag` are 0.
- R2: The strap pins are sampled on the first clock edge after reset release. Later changes on `strap_sa0`, `strap_sa1` or `strap_sa2` do not affect decoding until the next reset.
- R3: A byte with upper nibble 1010 and bits [3:2] equal to the latched {SA1,SA0} selects a memory target. Bit [1] = 0 selects the EEPROM (`sel_eeprom`). Bit [1] = 1 selects the ROM (`sel_rom`).
- R4: The sensor (`sel_sensor`) matches when bits [3:1] = {0, SA1, 0} and the upper nibble is the one chosen by the latched SA2 code. The nibble is 0011 for code 00 (low), 1001 for code 10 (floating) and 0101 for code 01 (high). The other two sensor nibbles do not match.
- R5: A latched SA2 code of 11 disables sensor matching. Memory matching is unaffected.
- R6: Bit [0] of the byte plays no part in matching. It is reported on `rd_flag` (1 = read).
- R7: A byte with upper nibble 0000 sets `reserved_flag` and `nomatch_flag`. It never asserts a select.
- R8: When no target matches, `nomatch_flag` is 1 and all selects are 0.
- R9: The results appear with `dec_valid` = 1 exactly one cycle after `addr_valid` is sampled high. On cycles with no strobe in the previous cycle, all outputs are 0.
- R10: A strobe sampled on the same edge as the strap capture (state `ST_ARMED`) gives a result with `nomatch_flag` = 1 and no select.
- R11: At most one select is high in any cycle. When `dec_valid` = 1 and `nomatch_flag` = 0, exactly one select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; strap capture follows its release |
| addr_byte | input | 8 | Assembled first byte of the transaction |
| addr_valid | input | 1 | One-cycle strobe qualifying `addr_byte` |
| strap_sa0 | input | 1 | Binary slot strap 0 |
| strap_sa1 | input | 1 | Binary slot strap 1 |
| strap_sa2 | input | 2 | Three-level strap code: 00 low, 01 high, 10 floating, 11 illegal |
| dec_valid | output | 1 | Decode result present this cycle |
| sel_eeprom | output | 1 | Scratch EEPROM addressed |
| sel_rom | output | 1 | Information ROM addressed |
| sel_sensor | output | 1 | Thermal sensor addressed |
| rd_flag | output | 1 | Direction bit of the byte (1 = read) |
| reserved_flag | output | 1 | Upper nibble was 0000 |
| nomatch_flag | output | 1 | No target claimed the byte |

## Verification
Two functions can fall in the same cycle: the one-time strap capture and the first address decode. Both happen on the first edge after reset release. The bench provokes this by raising `addr_valid` with a matching byte on the same negative edge that releases reset. It judges the outcome by requiring `nomatch_flag` with every select low. A second overlap is a reserved byte that also carries a read bit, so the reserved flag and the direction flag report together. This is checked from the vector table. Every strap configuration is scrambled on the pins right after capture, so each vector also checks that the latched copy, and not the live pins, drives the decode.

// File: rtl/smbdec_pkg.sv
package smbdec_pkg;

    localparam int ADDR_W  = 8;
    localparam int NIB_W   = 4;
    localparam int NUM_SNS = 3;

    localparam logic [NIB_W-1:0] MEM_NIB    = 4'b1010;
    localparam logic [NIB_W-1:0] RSVD_NIB   = 4'b0000;
    localparam logic [NIB_W-1:0] SNS_NIB_LO = 4'b0011;
    localparam logic [NIB_W-1:0] SNS_NIB_FL = 4'b1001;
    localparam logic [NIB_W-1:0] SNS_NIB_HI = 4'b0101;

    typedef enum logic [1:0] {
        SA2_LOW   = 2'b00,
        SA2_HIGH  = 2'b01,
        SA2_FLOAT = 2'b10,
        SA2_BAD   = 2'b11
    } sa2_code_t;

    typedef enum logic [1:0] {
        ST_ARMED      = 2'b00,
        ST_LOCKED_ALL = 2'b01,
        ST_LOCKED_MEM = 2'b10
    } lock_state_t;

    typedef struct packed {
        logic      sa0;
        logic      sa1;
        sa2_code_t sa2;
    } straps_t;

    typedef struct packed {
        logic eeprom;
        logic rom;
        logic sensor;
        logic reserved;
    } hit_t;

    function automatic sa2_code_t lane_code(input int idx);
        case (idx)
            0:       return SA2_LOW;
            1:       return SA2_FLOAT;
            default: return SA2_HIGH;
        endcase
    endfunction

    function automatic logic [NIB_W-1:0] lane_nib(input int idx);
        case (idx)
            0:       return SNS_NIB_LO;
            1:       return SNS_NIB_FL;
            default: return SNS_NIB_HI;
        endcase
    endfunction

endpackage

// File: rtl/smbdec_strap_latch.sv
module smbdec_strap_latch
    import smbdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_sa0,
    input  logic              pin_sa1,
    input  logic [1:0]        pin_sa2,
    output straps_t           straps_q,
    output logic              locked,
    output logic              sensor_en
);

    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:      state_d = (sa2_code_t'(pin_sa2) == SA2_BAD) ? ST_LOCKED_MEM
                                                                       : ST_LOCKED_ALL;
            ST_LOCKED_ALL: state_d = ST_LOCKED_ALL;
            ST_LOCKED_MEM: state_d = ST_LOCKED_MEM;
            default:       state_d = ST_ARMED;
        endcase
    end

    // capture register: loaded only when leaving ST_ARMED
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            straps_q <= '{sa0: 1'b0, sa1: 1'b0, sa2: SA2_BAD};
        end else if (state_q == ST_ARMED) begin
            straps_q.sa0 <= pin_sa0;
            straps_q.sa1 <= pin_sa1;
            straps_q.sa2 <= sa2_code_t'(pin_sa2);
        end
    end

    assign locked    = (state_q != ST_ARMED);
    assign sensor_en = (state_q == ST_LOCKED_ALL);

    assert_straps_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(straps_q));

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_bad_code_no_sensor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_en |-> (straps_q.sa2 != SA2_BAD));

endmodule

// File: rtl/smbdec_match.sv
module smbdec_match
    import smbdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  straps_t           straps,
    input  logic              sensor_en,
    output hit_t              hit
);

    localparam int HI_LSB = ADDR_W - NIB_W;

    logic [NIB_W-1:0]   upper;
    logic [NUM_SNS-1:0] lane_hit;
    logic               mem_ok;
    logic               sns_low_ok;

    assign upper      = addr[ADDR_W-1:HI_LSB];
    assign mem_ok     = (upper == MEM_NIB) && (addr[3:2] == {straps.sa1, straps.sa0});
    assign sns_low_ok = (addr[3:1] == {1'b0, straps.sa1, 1'b0});

    // one compare lane per three-level strap setting
    for (genvar g = 0; g < NUM_SNS; g++) begin : g_lane
        assign lane_hit[g] = (straps.sa2 == lane_code(g)) && (upper == lane_nib(g));
    end

    always_comb begin
        hit.reserved = (upper == RSVD_NIB);
        hit.eeprom   = mem_ok && !addr[1];
        hit.rom      = mem_ok &&  addr[1];
        hit.sensor   = sensor_en && sns_low_ok && (|lane_hit);
    end

    always_comb begin
        assert_reserved_nosel_R7: assert (!(hit.reserved && (hit.eeprom || hit.rom || hit.sensor)));
        assert_hit_onehot_R11: assert ($onehot0({hit.eeprom, hit.rom, hit.sensor}));
    end

endmodule

// File: rtl/smb_addr_decoder.sv
module smb_addr_decoder
    import smbdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr_byte,
    input  logic              addr_valid,
    input  logic              strap_sa0,
    input  logic              strap_sa1,
    input  logic [1:0]        strap_sa2,
    output logic              dec_valid,
    output logic              sel_eeprom,
    output logic              sel_rom,
    output logic              sel_sensor,
    output logic              rd_flag,
    output logic              reserved_flag,
    output logic              nomatch_flag
);

    straps_t straps;
    logic    locked;
    logic    sensor_en;
    hit_t    hit;
    logic    any_sel;

    smbdec_strap_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_sa0   (strap_sa0),
        .pin_sa1   (strap_sa1),
        .pin_sa2   (strap_sa2),
        .straps_q  (straps),
        .locked    (locked),
        .sensor_en (sensor_en)
    );

    smbdec_match u_match (
        .addr      (addr_byte),
        .straps    (straps),
        .sensor_en (sensor_en),
        .hit       (hit)
    );

    assign any_sel = locked && (hit.eeprom || hit.rom || hit.sensor);

    // output register: one-cycle result pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid     <= 1'b0;
            sel_eeprom    <= 1'b0;
            sel_rom       <= 1'b0;
            sel_sensor    <= 1'b0;
            rd_flag       <= 1'b0;
            reserved_flag <= 1'b0;
            nomatch_flag  <= 1'b0;
        end else begin
            dec_valid     <= addr_valid;
            sel_eeprom    <= addr_valid && locked && hit.eeprom;
            sel_rom       <= addr_valid && locked && hit.rom;
            sel_sensor    <= addr_valid && locked && hit.sensor;
            rd_flag       <= addr_valid && addr_byte[0];
            reserved_flag <= addr_valid && hit.reserved;
            nomatch_flag  <= addr_valid && !any_sel;
        end
    end

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_eeprom, sel_rom, sel_sensor}));

    assert_match_one_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !nomatch_flag) |-> ($countones({sel_eeprom, sel_rom, sel_sensor}) == 1));

    assert_nomatch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch_flag |-> !(sel_eeprom || sel_rom || sel_sensor));

    assert_reserved_nomatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_flag |-> nomatch_flag);

    assert_strobe_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> dec_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(sel_eeprom || sel_rom || sel_sensor || rd_flag
                         || reserved_flag || nomatch_flag));

    assert_armed_nomatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !locked) |=> (nomatch_flag && !sel_eeprom && !sel_rom && !sel_sensor));

endmodule

// File: tb/test_smb_addr_decoder.sv
module test_smb_addr_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       addr_valid = 1'b0;
    logic       strap_sa0 = 1'b0;
    logic       strap_sa1 = 1'b0;
    logic [1:0] strap_sa2 = 2'b00;
    logic       dec_valid, sel_eeprom, sel_rom, sel_sensor;
    logic       rd_flag, reserved_flag, nomatch_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    smb_addr_decoder i_smb_addr_decoder (
        .clk(clk), .rst_n(rst_n), .addr_byte(addr_byte), .addr_valid(addr_valid),
        .strap_sa0(strap_sa0), .strap_sa1(strap_sa1), .strap_sa2(strap_sa2),
        .dec_valid(dec_valid), .sel_eeprom(sel_eeprom), .sel_rom(sel_rom),
        .sel_sensor(sel_sensor), .rd_flag(rd_flag), .reserved_flag(reserved_flag),
        .nomatch_flag(nomatch_flag)
    );

    // vector: {sa2[1:0], sa1, sa0, addr[7:0], exp{eep,rom,sns,rd,rsv,nom}}
    localparam int NV = 28;
    localparam logic [17:0] VECS [NV] = '{
        // strap set A: SA2 low, SA1=1, SA0=0
        {2'b00, 1'b1, 1'b0, 8'hA8, 6'b100000},  // R3 eeprom
        {2'b00, 1'b1, 1'b0, 8'hAB, 6'b010100},  // R3 rom, R6 read
        {2'b00, 1'b1, 1'b0, 8'hA4, 6'b000001},  // R3 slot mismatch
        {2'b00, 1'b1, 1'b0, 8'h34, 6'b001000},  // R4 sensor
        {2'b00, 1'b1, 1'b0, 8'h35, 6'b001100},  // R4 R6
        {2'b00, 1'b1, 1'b0, 8'h30, 6'b000001},  // R4 low bits mismatch
        {2'b00, 1'b1, 1'b0, 8'h94, 6'b000001},  // R4 other nibble
        {2'b00, 1'b1, 1'b0, 8'h54, 6'b000001},  // R4 other nibble
        {2'b00, 1'b1, 1'b0, 8'h01, 6'b000111},  // R7 with read bit
        {2'b00, 1'b1, 1'b0, 8'h00, 6'b000011},  // R7
        {2'b00, 1'b1, 1'b0, 8'hFF, 6'b000101},  // R8
        // strap set B: SA2 floating, SA1=0, SA0=1
        {2'b10, 1'b0, 1'b1, 8'h91, 6'b001100},  // R4
        {2'b10, 1'b0, 1'b1, 8'h90, 6'b001000},  // R4
        {2'b10, 1'b0, 1'b1, 8'h94, 6'b000001},  // R4 SA1 mismatch
        {2'b10, 1'b0, 1'b1, 8'hA6, 6'b010000},  // R3
        {2'b10, 1'b0, 1'b1, 8'hA5, 6'b100100},  // R3 R6
        {2'b10, 1'b0, 1'b1, 8'h30, 6'b000001},  // R4 other nibble
        // strap set C: SA2 high, SA1=1, SA0=1
        {2'b01, 1'b1, 1'b1, 8'h54, 6'b001000},  // R4
        {2'b01, 1'b1, 1'b1, 8'h55, 6'b001100},  // R4 R6
        {2'b01, 1'b1, 1'b1, 8'hAC, 6'b100000},  // R3
        {2'b01, 1'b1, 1'b1, 8'hAF, 6'b010100},  // R3
        {2'b01, 1'b1, 1'b1, 8'h94, 6'b000001},  // R4 other nibble
        // strap set D: SA2 illegal, SA1=0, SA0=0
        {2'b11, 1'b0, 1'b0, 8'h30, 6'b000001},  // R5
        {2'b11, 1'b0, 1'b0, 8'h90, 6'b000001},  // R5 (pins later show floating)
        {2'b11, 1'b0, 1'b0, 8'h50, 6'b000001},  // R5
        {2'b11, 1'b0, 1'b0, 8'hA1, 6'b100100},  // R5 memory still works
        {2'b11, 1'b0, 1'b0, 8'hA2, 6'b010000},  // R5
        {2'b11, 1'b0, 1'b0, 8'h02, 6'b000011}   // R7
    };

    function automatic string tag_of(input logic [1:0] sa2, input logic [5:0] e);
        if (e[1])         return "R7 R2";
        if (sa2 == 2'b11) return "R5 R2";
        if (e[5] || e[4]) return "R3 R6 R11 R2";
        if (e[3])         return "R4 R6 R11 R2";
        return "R8 R2";
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valid,eep,rom,sns,rd,rsv,nom=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] outs();
        return {dec_valid, sel_eeprom, sel_rom, sel_sensor, rd_flag, reserved_flag, nomatch_flag};
    endfunction

    // reset, release, capture on the next edge, then scramble the pins (R2)
    task automatic reset_with(input logic [1:0] sa2, input logic sa1, input logic sa0);
        @(negedge clk);
        rst_n = 1'b0;
        strap_sa2 = sa2; strap_sa1 = sa1; strap_sa0 = sa0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 7'b0);
        strap_sa0 = ~sa0; strap_sa1 = ~sa1; strap_sa2 = sa2 ^ 2'b01;
    endtask

    task automatic send(input logic [7:0] a);
        @(negedge clk);
        addr_byte = a; addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] cur_cfg;
        cur_cfg = 6'h3F;
        repeat (2) @(negedge clk);
        check("R1 in reset", outs(), 7'b0);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VECS[i];
            if (v[17:14] != cur_cfg[3:0] || cur_cfg[5]) begin
                reset_with(v[17:16], v[15], v[14]);
                cur_cfg = {2'b00, v[17:14]};
            end
            send(v[13:6]);
            check(tag_of(v[17:16], v[5:0]), outs(), {1'b1, v[5:0]});
        end

        // R9: pulse lasts one cycle only
        @(negedge clk);
        check("R9 pulse ends", outs(), 7'b0);

        // R9: back-to-back strobes each give a result
        reset_with(2'b00, 1'b0, 1'b0);
        @(negedge clk);
        addr_byte = 8'hA0; addr_valid = 1'b1;
        @(negedge clk);
        addr_byte = 8'h30;
        check("R9 first of pair", outs(), 7'b1100000);
        @(negedge clk);
        addr_valid = 1'b0;
        check("R9 second of pair", outs(), 7'b1001000);

        // R10: strobe on the capture edge
        @(negedge clk);
        rst_n = 1'b0;
        strap_sa2 = 2'b00; strap_sa1 = 1'b0; strap_sa0 = 1'b0;
        repeat (2) @(negedge clk);
        addr_byte = 8'hA0; addr_valid = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        check("R10 armed strobe", outs(), 7'b1000001);
        send(8'hA0);
        check("R10 after lock", outs(), 7'b1100000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule